// File: doc/BRIEF.md
# Integer-Factor Sample Rate Reducer

This block lowers the rate of a continuous stream of unsigned 14-bit ADC codes by an integer factor. The stream arrives at up to one code per clock with a valid strobe. Each run of N valid codes forms a group, where N is the divisor. For each group the block emits one result together with a single-cycle valid pulse.

In keep mode the result is the first code of the group, and the rest of the group is discarded. In sum mode the result is the sum of every code in the group, shifted right by the smallest amount that holds the effective gain at or below 1024. The shift used is reported beside the result, so downstream logic can rescale it. A sync input drops any partial group, so that groups line up with the start of a capture.

The divisor and mode are sampled on the first code of each group and held until that group closes. Software can therefore rewrite them at any time without tearing a group.

Top module: `ds_downsampler`

## Requirements
- R1: While reset is held and on release, `out_valid_o` is 0, `out_data_o` is 0 and `out_shift_o` is 0.
- R2: Every group is exactly `div_i` valid codes long. Each group produces exactly one `out_valid_o` pulse, in the clock cycle directly after the cycle that accepts its last code.
- R3: With `mode_i` = 0 (keep), the result is the first code of the group, zero-extended to 24 bits, and `out_shift_o` is 0.
- R4: With `mode_i` = 1 (sum), the result is the group sum shifted right by s, where s is the smallest integer with `div_i` <= 1024 * 2^s. `out_shift_o` equals s.
- R5: A divisor of 0 or 1 gives groups of one code. Every code then appears unchanged one cycle later, with `out_shift_o` = 0, in both modes.
- R6: A high `sync_i` drops the partial group and produces no result for it. A valid code in the same cycle as `sync_i` is the first code of a new group.
- R7: A change of `div_i` or `mode_i` in the middle of a group takes effect from the first code of the next group.
- R8: Cycles with `smp_valid_i` low neither advance the group nor change the sum.
- R9: Shift boundaries follow R4 exactly: divisor 1024 gives shift 0, 1025 gives 1, 2048 gives 1, 2049 gives 2 and 4097 gives 3. Full-scale groups (every code 16383) never wrap the 32-bit sum or the 24-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Restart grouping; drops the partial group |
| mode_i | input | 1 | 0 = keep first code, 1 = sum with gain shift |
| div_i | input | 18 | Group length (0 is treated as 1) |
| smp_valid_i | input | 1 | Input code strobe |
| smp_data_i | input | 14 | Unsigned ADC code |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | 24 | Group result |
| out_shift_o | output | 4 | Right shift applied to the result |

## Verification
The bench targets the shift boundaries at 1024/1025, 2048/2049 and 4097, using full-scale codes. An off-by-one shift choice would show up there as a result that is twice or half too large, and a narrow accumulator would show up as a wrapped value. Groups with gaps in the strobe expose a counter that advances on idle cycles: such a design emits early and gives a wrong sum. The sync cases, with and without a code in the same cycle, catch a design that leaks stale partial sums or loses the code that starts the new group. Mid-group changes of divisor and mode catch a design that reads its settings live and closes the group at the wrong length or in the wrong mode.

// File: rtl/ds_pkg.sv
package ds_pkg;
  typedef enum logic {
    DS_KEEP = 1'b0,
    DS_SUM  = 1'b1
  } ds_mode_e;
endpackage

// File: rtl/ds_group_ctr.sv
module ds_group_ctr #(
  parameter int DIV_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             valid_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             first_o,
  output logic             last_o,
  output logic [DIV_W-1:0] len_o
);
  logic [DIV_W-1:0] cnt_q, len_q, cnt_eff, len_use, div_s;
  logic             at_start;

  // A zero divisor behaves as one.
  assign div_s    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign cnt_eff  = sync_i ? '0 : cnt_q;
  assign at_start = (cnt_eff == '0);
  assign len_use  = at_start ? div_s : len_q;
  assign first_o  = valid_i && at_start;
  assign last_o   = valid_i && (cnt_eff == len_use - DIV_W'(1));
  assign len_o    = len_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= DIV_W'(1);
    end else if (valid_i) begin
      cnt_q <= last_o ? '0 : cnt_eff + DIV_W'(1);
      if (at_start) len_q <= div_s;
    end else if (sync_i) begin
      cnt_q <= '0;
    end
  end

  assert_cnt_in_group_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) || (cnt_q < len_q));

  assert_sync_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (sync_i && !valid_i) |=> (cnt_q == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !sync_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ds_shift_sel.sv
module ds_shift_sel #(
  parameter int DIV_W     = 18,
  parameter int GAIN_LOG  = 10,
  parameter int MAX_SHIFT = DIV_W - GAIN_LOG,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DIV_W-1:0] len_i,
  output logic [SH_W-1:0]  shift_o
);
  function automatic logic [SH_W-1:0] pick_shift(input logic [DIV_W-1:0] len);
    logic [SH_W-1:0] s;
    s = '0;
    for (int k = 0; k < MAX_SHIFT; k++) begin
      if (longint'(len) > (longint'(1) << (GAIN_LOG + k))) s = SH_W'(k + 1);
    end
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) shift_o <= '0;
    else if (load_i) shift_o <= pick_shift(len_i);
  end

  assert_gain_cap_R4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (longint'($past(len_i)) <= (longint'(1) << (GAIN_LOG + int'(shift_o)))));

  assert_shift_min_R4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ((shift_o == '0) ||
      (longint'($past(len_i)) > (longint'(1) << (GAIN_LOG + int'(shift_o) - 1)))));
endmodule

// File: rtl/ds_accum.sv
module ds_accum
  import ds_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int DIV_W = 18,
  parameter int SH_W  = 4,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic             first_i,
  input  logic             last_i,
  input  ds_mode_e         mode_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o,
  output logic [SH_W-1:0]  out_shift_o
);
  localparam int ACC_W = SMP_W + DIV_W;

  logic [ACC_W-1:0] acc_q, sum_now, shifted;
  logic [SMP_W-1:0] keep_q, keep_now;
  ds_mode_e         mode_q, mode_use;
  logic [SH_W-1:0]  sh_use;

  assign sum_now  = first_i ? ACC_W'(data_i) : acc_q + ACC_W'(data_i);
  assign keep_now = first_i ? data_i : keep_q;
  // A group that starts here uses the live settings; a one-code group needs no shift.
  assign mode_use = first_i ? mode_i : mode_q;
  assign sh_use   = first_i ? '0 : shift_i;
  assign shifted  = sum_now >> sh_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= '0;
      keep_q      <= '0;
      mode_q      <= DS_KEEP;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_shift_o <= '0;
    end else begin
      out_valid_o <= valid_i && last_i;
      if (valid_i) begin
        acc_q  <= sum_now;
        keep_q <= keep_now;
        if (first_i) mode_q <= mode_i;
        if (last_i) begin
          if (mode_use == DS_SUM) begin
            out_data_o  <= shifted[OUT_W-1:0];
            out_shift_o <= sh_use;
          end else begin
            out_data_o  <= OUT_W'(keep_now);
            out_shift_o <= '0;
          end
        end
      end
    end
  end

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !first_i) |-> ({1'b0, acc_q} + (ACC_W+1)'(data_i) < ((ACC_W+1)'(1) << ACC_W)));
endmodule

// File: rtl/ds_downsampler.sv
module ds_downsampler
  import ds_pkg::*;
#(
  parameter  int SMP_W     = 14,
  parameter  int DIV_W     = 18,
  parameter  int GAIN_LOG  = 10,
  localparam int MAX_SHIFT = DIV_W - GAIN_LOG,
  localparam int SH_W      = $clog2(MAX_SHIFT + 1),
  localparam int OUT_W     = SMP_W + GAIN_LOG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o,
  output logic [SH_W-1:0]  out_shift_o
);
  logic             grp_first, grp_last;
  logic [DIV_W-1:0] grp_len;
  logic [SH_W-1:0]  grp_shift;

  ds_group_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .sync_i  (sync_i),
    .valid_i (smp_valid_i),
    .div_i   (div_i),
    .first_o (grp_first),
    .last_o  (grp_last),
    .len_o   (grp_len)
  );

  ds_shift_sel #(
    .DIV_W     (DIV_W),
    .GAIN_LOG  (GAIN_LOG),
    .MAX_SHIFT (MAX_SHIFT),
    .SH_W      (SH_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (grp_first),
    .len_i   (grp_len),
    .shift_o (grp_shift)
  );

  ds_accum #(
    .SMP_W (SMP_W),
    .DIV_W (DIV_W),
    .SH_W  (SH_W),
    .OUT_W (OUT_W)
  ) u_acc (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (smp_valid_i),
    .data_i      (smp_data_i),
    .first_i     (grp_first),
    .last_i      (grp_last),
    .mode_i      (ds_mode_e'(mode_i)),
    .shift_i     (grp_shift),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_shift_o (out_shift_o)
  );

  assert_out_after_last_R2: assert property (@(posedge clk) disable iff (rst)
    grp_last |=> out_valid_o);

  assert_no_spurious_out_R2: assert property (@(posedge clk) disable iff (rst)
    !grp_last |=> !out_valid_o);

  assert_single_code_unchanged_R5: assert property (@(posedge clk) disable iff (rst)
    (grp_first && grp_last) |=> (out_shift_o == '0) && (out_data_o == OUT_W'($past(smp_data_i))));
endmodule

// File: tb/ds_downsampler_tb.sv
module ds_downsampler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [17:0] div_i = 18'd1;
  logic        smp_valid_i = 1'b0;
  logic [13:0] smp_data_i = '0;
  logic        out_valid_o;
  logic [23:0] out_data_o;
  logic [3:0]  out_shift_o;

  ds_downsampler u_dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .mode_i(mode_i), .div_i(div_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_shift_o(out_shift_o)
  );

  always #10 clk = ~clk;

  int     n_checks = 0;
  int     n_err = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // capture of outputs
  longint got_data [64];
  longint got_shift[64];
  longint got_cyc  [64];
  int     got_n = 0;
  always @(negedge clk) begin
    if (!rst && out_valid_o) begin
      if (got_n < 64) begin
        got_data[got_n]  = out_data_o;
        got_shift[got_n] = out_shift_o;
        got_cyc[got_n]   = cyc;
      end
      got_n = got_n + 1;
    end
  end

  // expectations built from the requirements
  longint exp_data [64];
  longint exp_shift[64];
  longint exp_cyc  [64];
  int     exp_n = 0;
  int     cfg_div = 1;
  bit     cfg_mode = 0;
  longint m_cnt, m_len, m_acc, m_keep;
  bit     m_mode;

  function automatic longint want_shift(longint len);
    longint s = 0;
    while (len > (longint'(1024) << s)) s++;
    return s;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int d, bit s);
    longint sh;
    @(negedge clk);
    smp_valid_i = v;
    smp_data_i  = 14'(d);
    sync_i      = s;
    div_i       = 18'(cfg_div);
    mode_i      = cfg_mode;
    if (s) m_cnt = 0;
    if (v) begin
      if (m_cnt == 0) begin
        m_len  = (cfg_div == 0) ? 1 : cfg_div;
        m_mode = cfg_mode;
        m_acc  = 0;
        m_keep = d;
      end
      m_acc += d;
      m_cnt++;
      if (m_cnt == m_len) begin
        sh = m_mode ? want_shift(m_len) : 0;
        if (exp_n < 64) begin
          exp_data[exp_n]  = m_mode ? (m_acc >> sh) : m_keep;
          exp_shift[exp_n] = sh;
          exp_cyc[exp_n]   = cyc + 1;
        end
        exp_n++;
        m_cnt = 0;
      end
    end
  endtask

  task automatic settle_and_compare(string req);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    chk(req, "result count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
      chk(req, "data", got_data[i], exp_data[i]);
      chk(req, "shift", got_shift[i], exp_shift[i]);
      chk(req, "cycle", got_cyc[i], exp_cyc[i]);
    end
    got_n = 0;
    exp_n = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid in reset", out_valid_o, 0);
    chk("R1", "data in reset", out_data_o, 0);
    chk("R1", "shift in reset", out_shift_o, 0);
    rst = 1'b0;
    m_cnt = 0;
    @(negedge clk);
    chk("R1", "valid after release", out_valid_o, 0);
  endtask

  task automatic t_keep();  // R2 R3
    cfg_div = 4; cfg_mode = 0;
    for (int i = 0; i < 12; i++) step(1, (i * 611 + 3) % 16384, 0);
    settle_and_compare("R3");
  endtask

  task automatic t_sum_gaps();  // R4 R8
    cfg_div = 5; cfg_mode = 1;
    for (int i = 0; i < 15; i++) begin
      step(1, (i * 977 + 100) % 16384, 0);
      if (i % 3 == 1) begin step(0, 1234, 0); step(0, 4321, 0); end
    end
    settle_and_compare("R8");
  endtask

  task automatic t_single();  // R5
    cfg_div = 1; cfg_mode = 1;
    for (int i = 0; i < 4; i++) step(1, 16383 - i * 5, 0);
    cfg_mode = 0;
    for (int i = 0; i < 3; i++) step(1, 77 + i, 0);
    cfg_div = 0; cfg_mode = 1;
    for (int i = 0; i < 3; i++) step(1, 9000 + i, 0);
    settle_and_compare("R5");
  endtask

  task automatic t_sync();  // R6
    cfg_div = 4; cfg_mode = 1;
    step(1, 500, 0); step(1, 600, 0);
    step(0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 10 + i, 0);
    step(1, 700, 0); step(1, 800, 0); step(1, 900, 0);
    step(1, 3000, 1);
    for (int i = 0; i < 3; i++) step(1, 20 + i, 0);
    settle_and_compare("R6");
  endtask

  task automatic t_change();  // R7
    cfg_div = 3; cfg_mode = 1;
    step(1, 100, 0);
    cfg_div = 2; cfg_mode = 0;
    step(1, 200, 0); step(1, 300, 0);
    step(1, 400, 0); step(1, 500, 0);
    cfg_div = 3; cfg_mode = 1;
    step(1, 600, 0);
    cfg_div = 1; cfg_mode = 0;
    step(1, 700, 0); step(1, 800, 0);
    settle_and_compare("R7");
  endtask

  task automatic t_bounds();  // R4 R9
    int lens[5] = '{1024, 1025, 2048, 2049, 4097};
    cfg_mode = 1;
    foreach (lens[j]) begin
      cfg_div = lens[j];
      for (int i = 0; i < lens[j]; i++) step(1, 16383, 0);
    end
    cfg_div = 1500;
    for (int i = 0; i < 1500; i++) step(1, (i * 37) % 16384, 0);
    settle_and_compare("R9");
  endtask

  initial begin
    t_reset();
    t_keep();
    t_sum_gaps();
    t_single();
    t_sync();
    t_change();
    t_bounds();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule